// File: doc/BRIEF.md
# Volume and Mute Pushbutton Controller

This block turns four slow user control pins into audio control state: a volume index, a mute flag and a speaker/earpiece selection. Two volume pins each move the index one step per qualified press. A qualified press is a pin held high for a minimum time after the pins were low for a minimum time. While the pin stays high, the index keeps stepping at a fixed interval, stopping at a programmable ceiling or at zero.

A mute pin flips the mute flag once per qualified press, however long it is held. An earpiece pin picks a reduced-gain earpiece mode on its falling edge and speaker mode on its rising edge. All durations are counted in pulses of a one-millisecond tick enable, so the block runs from any system clock.

When a serial host owns the mute and earpiece pins, an ownership input makes the block ignore both pins and keep the current state. The pins are expected to be already synchronous to `clk`.

Top module: `vol_mute_ctrl`

## Requirements
- R1: After reset the volume index equals the parameter VOL_INIT (default 8), `muted` is 0 and `earpiece` is 0 (speaker mode).
- R2: With exactly one volume pin high, the first step happens on the tick that completes PRESS_MS (default 150) consecutive high ticks; after 149 ticks there is no step.
- R3: While the same single volume pin stays high after its first step, a further step happens every REPEAT_MS (default 1000) ticks.
- R4: An up step never raises the index above `vol_max`, and a down step never takes it below 0; the index changes by at most one per clock.
- R5: After a volume press has stepped, no new press is recognised until both volume pins have been low for RELEASE_MS (default 100) consecutive ticks; a shorter gap followed by a long hold gives no step at all.
- R6: While both volume pins are high together, the volume index does not change.
- R7: The mute flag toggles on the tick that completes MUTE_MS (default 100) consecutive high ticks of the mute pin, and does not toggle again until the pin has gone low and is held high for MUTE_MS ticks once more.
- R8: A falling edge of the earpiece pin sets `earpiece` to 1 one clock later; a rising edge clears it to 0 one clock later.
- R9: While `host_owns` is 1, the mute and earpiece pins have no effect: `muted` and `earpiece` hold their values, and returning ownership with the earpiece pin already low produces no edge.
- R10: All duration counters advance only on clocks where `tick_ms` is 1; holding a volume pin with no ticks never steps the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-clock enable pulse per millisecond |
| vol_up | input | 1 | Volume-up button, active high |
| vol_dn | input | 1 | Volume-down button, active high |
| mute_btn | input | 1 | Mute button, active high |
| ear_pin | input | 1 | Earpiece/speaker select pin, edge sensitive |
| host_owns | input | 1 | High while the serial host uses the mute and earpiece pins |
| vol_max | input | VOL_W | Highest allowed volume index |
| vol_idx | output | VOL_W | Current volume index |
| muted | output | 1 | High while muted |
| earpiece | output | 1 | High in earpiece (reduced gain) mode |

## Verification
The bench aims at the exact tick boundaries: one tick short of the press, repeat and mute windows, where a design off by one would step or toggle a tick early or late. It releases for one tick less than the low window before a long hold, which catches a design that re-arms too soon and steps mid-hold. It drives both volume pins together and runs the index into the ceiling and the floor, where a wrong saturation would wrap to 0 or 31. It holds a pin with no ticks, and hands the pins back from the host with the earpiece pin low, where a design that kept stale edge history would switch modes without any edge.

// File: rtl/vol_mute_ctrl.sv
module vol_mute_ctrl #(
  parameter int VOL_W      = 5,
  parameter int VOL_INIT   = 8,
  parameter int PRESS_MS   = 150,
  parameter int RELEASE_MS = 100,
  parameter int REPEAT_MS  = 1000,
  parameter int MUTE_MS    = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             vol_up,
  input  logic             vol_dn,
  input  logic             mute_btn,
  input  logic             ear_pin,
  input  logic             host_owns,
  input  logic [VOL_W-1:0] vol_max,
  output logic [VOL_W-1:0] vol_idx,
  output logic             muted,
  output logic             earpiece
);

  localparam int HOLD_TOP = (REPEAT_MS > PRESS_MS) ? REPEAT_MS : PRESS_MS;
  localparam int HW = $clog2(HOLD_TOP + 1);
  localparam int LW = $clog2(RELEASE_MS + 1);
  localparam int MW = $clog2(MUTE_MS + 1);

  logic [HW-1:0] hcnt;
  logic [LW-1:0] lcnt;
  logic [MW-1:0] mcnt;
  logic          fired, armed, dir_q, ear_q;

  wire solo     = vol_up ^ vol_dn;
  wire quiet    = ~vol_up & ~vol_dn;
  wire [HW-1:0] hnext = hcnt + 1'b1;
  wire dir_flip = solo & (fired | (hcnt != '0)) & (vol_up != dir_q);
  wire first_hit = tick_ms & solo & ~dir_flip & ~fired & armed & (hnext == HW'(PRESS_MS));
  wire rep_hit   = tick_ms & solo & ~dir_flip & fired & (hnext == HW'(REPEAT_MS));
  wire step      = first_hit | rep_hit;

  wire mpin = mute_btn & ~host_owns;
  wire fall = ~host_owns & ear_q & ~ear_pin;
  wire rise = ~host_owns & ~ear_q & ear_pin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt  <= '0;
      fired <= 1'b0;
      dir_q <= 1'b0;
    end else if (!solo) begin
      hcnt  <= '0;
      fired <= 1'b0;
    end else begin
      dir_q <= vol_up;
      if (dir_flip) begin
        hcnt  <= '0;
        fired <= 1'b0;
      end else if (tick_ms) begin
        if (step) begin
          hcnt  <= '0;
          fired <= 1'b1;
        end else if (fired || hcnt != HW'(PRESS_MS)) begin
          hcnt <= hnext;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcnt  <= LW'(RELEASE_MS);
      armed <= 1'b1;
    end else begin
      if (!quiet) lcnt <= '0;
      else if (tick_ms && lcnt != LW'(RELEASE_MS)) lcnt <= lcnt + 1'b1;
      if (first_hit) armed <= 1'b0;
      else if (quiet && tick_ms && lcnt + 1'b1 == LW'(RELEASE_MS)) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vol_idx <= VOL_W'(VOL_INIT);
    else if (step) begin
      if (vol_up) begin
        if (vol_idx < vol_max) vol_idx <= vol_idx + 1'b1;
      end else if (vol_idx != '0) begin
        vol_idx <= vol_idx - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt  <= '0;
      muted <= 1'b0;
    end else if (!mpin) begin
      mcnt <= '0;
    end else if (tick_ms && mcnt != MW'(MUTE_MS)) begin
      mcnt <= mcnt + 1'b1;
      if (mcnt + 1'b1 == MW'(MUTE_MS)) muted <= ~muted;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ear_q    <= 1'b1;
      earpiece <= 1'b0;
    end else begin
      ear_q <= ear_pin;
      if (fall) earpiece <= 1'b1;
      else if (rise) earpiece <= 1'b0;
    end
  end

  p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_idx == $past(vol_idx)) || (vol_idx == $past(vol_idx) + 1'b1) || (vol_idx == $past(vol_idx) - 1'b1));

  p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_idx > $past(vol_idx)) |-> (vol_idx <= $past(vol_max)));

  p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_up && vol_dn) |=> $stable(vol_idx));

  p_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_ms |=> ($stable(vol_idx) && $stable(muted)));

  p_host_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_owns |=> ($stable(muted) && $stable(earpiece)));

endmodule

// File: tb/vol_mute_ctrl_tb.sv
module vol_mute_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b1;
  logic vol_up = 1'b0, vol_dn = 1'b0, mute_btn = 1'b0, ear_pin = 1'b1, host_owns = 1'b0;
  logic [4:0] vol_max = 5'd20;
  logic [4:0] vol_idx;
  logic muted, earpiece;
  int nchk = 0, nfail = 0, cyc = 0;

  always #5 clk = ~clk;

  vol_mute_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .vol_up(vol_up), .vol_dn(vol_dn),
    .mute_btn(mute_btn), .ear_pin(ear_pin), .host_owns(host_owns), .vol_max(vol_max),
    .vol_idx(vol_idx), .muted(muted), .earpiece(earpiece)
  );

  // {up, dn, mute, cycles, expected vol, expected muted}
  localparam logic [24:0] VEC [20] = '{
    {3'b100, 16'd149,  5'd8,  1'b0},  // R2 one tick short
    {3'b100, 16'd1,    5'd9,  1'b0},  // R2 first step
    {3'b100, 16'd999,  5'd9,  1'b0},  // R3 short of repeat
    {3'b100, 16'd1,    5'd10, 1'b0},  // R3 repeat
    {3'b100, 16'd1000, 5'd11, 1'b0},  // R3
    {3'b000, 16'd99,   5'd11, 1'b0},  // R5 gap too short
    {3'b100, 16'd200,  5'd11, 1'b0},  // R5 no step
    {3'b000, 16'd100,  5'd11, 1'b0},  // R5 re-arm
    {3'b100, 16'd150,  5'd12, 1'b0},  // R5 press accepted
    {3'b000, 16'd100,  5'd12, 1'b0},
    {3'b010, 16'd150,  5'd11, 1'b0},  // R2 down
    {3'b010, 16'd1000, 5'd10, 1'b0},  // R3 down
    {3'b000, 16'd100,  5'd10, 1'b0},
    {3'b110, 16'd300,  5'd10, 1'b0},  // R6 both high
    {3'b000, 16'd100,  5'd10, 1'b0},
    {3'b001, 16'd99,   5'd10, 1'b0},  // R7 short
    {3'b001, 16'd1,    5'd10, 1'b1},  // R7 toggle
    {3'b001, 16'd500,  5'd10, 1'b1},  // R7 once per hold
    {3'b000, 16'd1,    5'd10, 1'b1},
    {3'b001, 16'd100,  5'd10, 1'b0}   // R7 toggle back
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic u, input logic d, input logic m, input int n);
    vol_up = u; vol_dn = d; mute_btn = m;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vol", vol_idx, 8);
    chk("R1 muted", muted, 0);
    chk("R1 earpiece", earpiece, 0);

    for (int i = 0; i < 20; i++) begin
      apply(VEC[i][24], VEC[i][23], VEC[i][22], int'(VEC[i][21:6]));
      chk($sformatf("table %0d vol", i), vol_idx, int'(VEC[i][5:1]));
      chk($sformatf("table %0d muted", i), muted, int'(VEC[i][0]));
    end

    vol_max = 5'd12;
    apply(1, 0, 0, 150);  chk("R4 up", vol_idx, 11);
    apply(1, 0, 0, 1000); chk("R4 reach cap", vol_idx, 12);
    apply(1, 0, 0, 2000); chk("R4 cap hold", vol_idx, 12);
    apply(0, 0, 0, 100);
    apply(0, 1, 0, 150);  chk("R4 down", vol_idx, 11);
    apply(0, 1, 0, 11000); chk("R4 reach floor", vol_idx, 0);
    apply(0, 1, 0, 2000); chk("R4 floor hold", vol_idx, 0);
    apply(0, 0, 0, 100);

    tick_ms = 1'b0;
    apply(1, 0, 0, 500);  chk("R10 no tick", vol_idx, 0);
    tick_ms = 1'b1;
    apply(1, 0, 0, 149);  chk("R10 R2 149 ticks", vol_idx, 0);
    apply(1, 0, 0, 1);    chk("R10 R2 150 ticks", vol_idx, 1);
    apply(0, 0, 0, 1);

    ear_pin = 1'b0; apply(0, 0, 0, 1); chk("R8 fall", earpiece, 1);
    ear_pin = 1'b1; apply(0, 0, 0, 1); chk("R8 rise", earpiece, 0);

    host_owns = 1'b1;
    ear_pin = 1'b0; apply(0, 0, 0, 5); chk("R9 ear ignored", earpiece, 0);
    apply(0, 0, 1, 200); chk("R9 mute ignored", muted, 0);
    apply(0, 0, 0, 1);
    host_owns = 1'b0;
    apply(0, 0, 0, 5); chk("R9 no stale edge", earpiece, 0);
    ear_pin = 1'b1; apply(0, 0, 0, 2);
    ear_pin = 1'b0; apply(0, 0, 0, 1); chk("R9 R8 edges back", earpiece, 1);
    apply(0, 0, 1, 100); chk("R9 R7 mute back", muted, 1);

    finish_run();
  end
endmodule